// File: doc/BRIEF.md
# Transmit Pre-emphasis Tap Adaptation

This block tunes the weights of a transmit FIR pre-emphasis filter using feedback from the receiver. For every transmitted bit it takes one signed received sample, together with the transmitted bits that line up with each filter tap. It keeps a register for the target received level and one register per tap weight, and it drives the whole weight vector back to the filter.

Only the main-cursor weight and the first post-cursor weight adapt; the other taps keep the values loaded at reset. A sign-data LMS rule drives the adaptation. The block considers one bit in every `DECIM`, and it updates only when the main-cursor bit of that bit is a one. The error is the received sample minus the target level. A programmable arithmetic right shift scales the error into a step. Each adaptive weight moves against the step when its own tap bit is a one and with the step when that bit is a zero. The target level always moves by the step. All results saturate to their signed ranges. Software can pause adaptation with an enable input, and the outputs then hold their values.

Top module: `preemph_adapt`

## Requirements
- R1: A synchronous active-low reset loads each weight k from `initTaps[k*WW +: WW]` and the level from `initLevel`, and it clears the bit-phase counter.
- R2: Every tap other than index PRE_TAPS (main) and PRE_TAPS+1 (first post) keeps its reset value.
- R3: With `adaptEn`=1 and `bitValid`=1, every bit advances a counter that wraps modulo DECIM. Only the bit that arrives while the counter is at DECIM-1 (the 4th, 8th, ... bit after reset) can update, and only when `txBits[PRE_TAPS]`=1. Every other bit leaves all weights and the level unchanged.
- R4: The step is (rxSample − level) arithmetically shifted right by `stepShift`, rounding toward minus infinity (error −5 with shift 1 gives −3).
- R5: On an update the main weight becomes weight − step.
- R6: On an update the first post-cursor weight becomes weight − step when `txBits[PRE_TAPS+1]`=1 and weight + step when it is 0.
- R7: On an update the level becomes level + step.
- R8: Weights saturate to [−2^(WW−1), 2^(WW−1)−1] and the level saturates to [−2^(SW−1), 2^(SW−1)−1].
- R9: With `adaptEn`=0 the counter does not advance and all outputs hold, whatever the other inputs do.
- R10: Bits of `txBits` at fixed-tap positions have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads initial values |
| adaptEn | input | 1 | Enables adaptation and bit counting |
| bitValid | input | 1 | Marks a cycle that carries one received bit |
| rxSample | input | SW | Signed received sample for this bit |
| txBits | input | NUM_TAPS | Transmitted bit at each tap, 1 = +1, 0 = −1 |
| stepShift | input | SHW | Right-shift amount that sets the step size |
| initTaps | input | NUM_TAPS*WW | Signed reset weights, tap k at bits k*WW |
| initLevel | input | SW | Signed reset target level |
| tapWeights | output | NUM_TAPS*WW | Current signed weights, tap k at bits k*WW |
| level | output | SW | Current signed target level |

## Verification
The bench builds the block with its defaults: five taps with two pre-cursor taps, 12-bit weights and samples, a decimation of four and a 4-bit shift. At 12 bits a single update with shift zero can push both a weight and the level past their limits, so the saturation corners can be reached in one step. A decimation of four is short enough that a table of sixteen bits crosses several update phases, both with the main bit at one and at zero and with enable toggled.

// File: rtl/preemph_adapt_pkg.sv
package preemph_adapt_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic update;   // apply one LMS step this cycle
  } adaptStrobe_t;
endpackage

// File: rtl/preemph_adapt_ctrl.sv
module preemph_adapt_ctrl
  import preemph_adapt_pkg::*;
#(
  parameter int DECIM = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adaptEn,
  input  logic         bitValid,
  input  logic         mainBit,
  output adaptStrobe_t strobe
);
  localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [CW-1:0] phaseCnt;
  logic          advance;
  logic          lastPhase;

  assign advance   = adaptEn & bitValid;
  assign lastPhase = (int'(phaseCnt) == DECIM - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       phaseCnt <= '0;
    else if (advance) phaseCnt <= lastPhase ? '0 : phaseCnt + 1'b1;
  end

  assign strobe.update = advance & lastPhase & mainBit;

  // R3: counter stays inside its modulo range
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phaseCnt) < DECIM);

  // R9: no counting while adaptation is paused
  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adaptEn |=> $stable(phaseCnt));
endmodule

// File: rtl/preemph_adapt_dp.sv
module preemph_adapt_dp
  import preemph_adapt_pkg::*;
#(
  parameter int NUM_TAPS = 5,
  parameter int PRE_TAPS = 2,
  parameter int WW       = 12,
  parameter int SW       = 12,
  parameter int SHW      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  adaptStrobe_t           strobe,
  input  logic signed [SW-1:0]   rxSample,
  input  logic [NUM_TAPS-1:0]    txBits,
  input  logic [SHW-1:0]         stepShift,
  input  logic [NUM_TAPS*WW-1:0] initTaps,
  input  logic signed [SW-1:0]   initLevel,
  output logic [NUM_TAPS*WW-1:0] tapWeights,
  output logic signed [SW-1:0]   level
);
  localparam int MAIN = PRE_TAPS;
  localparam int POST = PRE_TAPS + 1;
  localparam int EW   = ((WW > SW) ? WW : SW) + 2;

  localparam logic signed [EW-1:0] W_MAX = EW'((64'sd1 <<< (WW - 1)) - 1);
  localparam logic signed [EW-1:0] W_MIN = -EW'(64'sd1 <<< (WW - 1));
  localparam logic signed [EW-1:0] S_MAX = EW'((64'sd1 <<< (SW - 1)) - 1);
  localparam logic signed [EW-1:0] S_MIN = -EW'(64'sd1 <<< (SW - 1));

  logic signed [WW-1:0] wReg [NUM_TAPS];
  logic signed [SW-1:0] levelReg;
  logic signed [EW-1:0] errExt;
  logic signed [EW-1:0] stepDelta;
  logic signed [EW-1:0] levelSum;
  logic                 unusedTx;

  assign errExt    = EW'(rxSample) - EW'(levelReg);
  assign stepDelta = errExt >>> stepShift;
  assign levelSum  = EW'(levelReg) + stepDelta;
  assign unusedTx  = ^txBits;

  function automatic logic signed [EW-1:0] clampTo(
    input logic signed [EW-1:0] v,
    input logic signed [EW-1:0] lo,
    input logic signed [EW-1:0] hi);
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)             levelReg <= initLevel;
    else if (strobe.update) levelReg <= SW'(clampTo(levelSum, S_MIN, S_MAX));
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == MAIN || k == POST) begin : g_adapt
      logic signed [EW-1:0] wNext;
      assign wNext = txBits[k] ? (EW'(wReg[k]) - stepDelta)
                               : (EW'(wReg[k]) + stepDelta);
      always_ff @(posedge clk) begin
        if (!rst_n)             wReg[k] <= initTaps[k*WW +: WW];
        else if (strobe.update) wReg[k] <= WW'(clampTo(wNext, W_MIN, W_MAX));
      end
      // R3: adaptive weight moves only on an update
      assert_hold_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.update |=> $stable(wReg[k]));
    end else begin : g_fixed
      always_ff @(posedge clk) begin
        if (!rst_n) wReg[k] <= initTaps[k*WW +: WW];
      end
      // R2: fixed tap never moves after reset
      assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(wReg[k]));
    end
    assign tapWeights[k*WW +: WW] = wReg[k];
  end

  assign level = levelReg;

  // R3: level only changes after a bit whose main-cursor value was one
  assert_update_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(levelReg)) |-> $past(txBits[MAIN]));

  // R7: a positive step never lowers the level
  assert_level_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && stepDelta > 0) |=> levelReg >= $past(levelReg));

  // R7: a negative step never raises the level
  assert_level_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && stepDelta < 0) |=> levelReg <= $past(levelReg));
endmodule

// File: rtl/preemph_adapt.sv
module preemph_adapt
  import preemph_adapt_pkg::*;
#(
  parameter int NUM_TAPS = 5,
  parameter int PRE_TAPS = 2,
  parameter int WW       = 12,
  parameter int SW       = 12,
  parameter int DECIM    = 4,
  parameter int SHW      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adaptEn,
  input  logic                   bitValid,
  input  logic signed [SW-1:0]   rxSample,
  input  logic [NUM_TAPS-1:0]    txBits,
  input  logic [SHW-1:0]         stepShift,
  input  logic [NUM_TAPS*WW-1:0] initTaps,
  input  logic signed [SW-1:0]   initLevel,
  output logic [NUM_TAPS*WW-1:0] tapWeights,
  output logic signed [SW-1:0]   level
);
  adaptStrobe_t strobe;

  preemph_adapt_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .adaptEn  (adaptEn),
    .bitValid (bitValid),
    .mainBit  (txBits[PRE_TAPS]),
    .strobe   (strobe)
  );

  preemph_adapt_dp #(
    .NUM_TAPS (NUM_TAPS),
    .PRE_TAPS (PRE_TAPS),
    .WW       (WW),
    .SW       (SW),
    .SHW      (SHW)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rxSample   (rxSample),
    .txBits     (txBits),
    .stepShift  (stepShift),
    .initTaps   (initTaps),
    .initLevel  (initLevel),
    .tapWeights (tapWeights),
    .level      (level)
  );
endmodule

// File: tb/preemph_adapt_tb.sv
module preemph_adapt_tb;
  localparam int NT = 5;
  localparam int WW = 12;
  localparam int SW = 12;
  localparam int NV = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              adaptEn = 1'b0;
  logic              bitValid = 1'b0;
  logic signed [SW-1:0] rxSample = '0;
  logic [NT-1:0]     txBits = '0;
  logic [3:0]        stepShift = '0;
  logic [NT*WW-1:0]  initTaps;
  logic signed [SW-1:0] initLevel;
  logic [NT*WW-1:0]  tapWeights;
  logic signed [SW-1:0] level;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mW [NT];
  int mLev;
  int mCnt;

  always #10 clk = ~clk;

  preemph_adapt u_dut (
    .clk(clk), .rst_n(rst_n), .adaptEn(adaptEn), .bitValid(bitValid),
    .rxSample(rxSample), .txBits(txBits), .stepShift(stepShift),
    .initTaps(initTaps), .initLevel(initLevel),
    .tapWeights(tapWeights), .level(level)
  );

  // {en, shift[3:0], txBits[4:0], rx[11:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 4'd2, 5'b11111, 12'(700)},
    {1'b1, 4'd2, 5'b00100, 12'(-100)},
    {1'b1, 4'd2, 5'b00000, 12'(900)},
    {1'b1, 4'd2, 5'b01100, 12'(820)},
    {1'b1, 4'd1, 5'b10011, 12'(300)},
    {1'b0, 4'd1, 5'b01100, 12'(-900)},
    {1'b1, 4'd1, 5'b00100, 12'(10)},
    {1'b1, 4'd1, 5'b00100, 12'(480)},
    {1'b1, 4'd3, 5'b10111, 12'(1500)},
    {1'b1, 4'd0, 5'b01100, 12'(-2000)},
    {1'b1, 4'd0, 5'b00100, 12'(2000)},
    {1'b1, 4'd0, 5'b00000, 12'(1200)},
    {1'b1, 4'd3, 5'b01000, 12'(-50)},
    {1'b1, 4'd3, 5'b01100, 12'(-50)},
    {1'b1, 4'd3, 5'b11111, 12'(200)},
    {1'b1, 4'd4, 5'b00111, 12'(-1200)}
  };

  function automatic int sat(input int v, input int w);
    int hi = (1 <<< (w - 1)) - 1;
    int lo = -(1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int wOut(input int k);
    return int'($signed(tapWeights[k*WW +: WW]));
  endfunction

  task automatic modelReset();
    for (int k = 0; k < NT; k++) mW[k] = int'($signed(initTaps[k*WW +: WW]));
    mLev = int'(initLevel);
    mCnt = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; bitValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    modelReset();
  endtask

  // drive one bit, advance the model, return at the next negedge
  task automatic sendBit(input bit en, input int sh, input logic [NT-1:0] tx, input int rx);
    int e, d;
    @(negedge clk);
    adaptEn = en; stepShift = 4'(sh); txBits = tx; rxSample = SW'(rx); bitValid = 1'b1;
    if (en) begin
      if (mCnt == 3 && tx[2]) begin
        e = rx - mLev;
        d = e >>> sh;
        mW[2] = sat(mW[2] - d, WW);
        mW[3] = sat(tx[3] ? mW[3] - d : mW[3] + d, WW);
        mLev  = sat(mLev + d, SW);
      end
      mCnt = (mCnt + 1) % 4;
    end
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    checks++;
    for (int k = 0; k < NT; k++) begin
      if (wOut(k) != mW[k]) begin
        errors++;
        $display("FAIL %s: tap %0d actual=%0d expected=%0d", tag, k, wOut(k), mW[k]);
        return;
      end
    end
    if (int'(level) != mLev) begin
      errors++;
      $display("FAIL %s: level actual=%0d expected=%0d", tag, level, mLev);
    end
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    initTaps  = {12'(213), 12'(-560), 12'(980), 12'(-90), 12'(-20)};
    initLevel = 12'(600);
    doReset();

    // R1: reset values
    checkVal("R1 main tap", wOut(2), 980);
    checkVal("R1 pre tap", wOut(1), -90);
    checkVal("R1 level", int'(level), 600);

    // R3: three ineligible bits leave state alone
    sendBit(1, 1, 5'b00100, -700);
    sendBit(1, 1, 5'b00100, -700);
    sendBit(1, 1, 5'b00100, -700);
    checkVal("R3 no update before 4th bit", int'(level), 600);
    // R4/R5/R6/R7: error -5, shift 1 -> step -3
    sendBit(1, 1, 5'b00100, 595);
    checkVal("R4 floor step level", int'(level), 597);
    checkVal("R5 main tap", wOut(2), 983);
    checkVal("R6 post tap bit zero", wOut(3), -563);

    // table walk: R3 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      sendBit(VEC[i][21], int'(VEC[i][20:17]), VEC[i][16:12],
              int'($signed(VEC[i][11:0])));
      checkAll($sformatf("R3/R5/R6/R7/R10 vector %0d", i));
    end

    // R9: paused, eligible-looking bits change nothing
    for (int i = 0; i < 8; i++) sendBit(0, 0, 5'b01100, -2048);
    checkAll("R9 paused hold");

    // R2: fixed taps unchanged after all activity
    checkVal("R2 tap0", wOut(0), -20);
    checkVal("R2 tap1", wOut(1), -90);
    checkVal("R2 tap4", wOut(4), 213);

    // R8: saturation in one step
    initTaps  = {12'(213), 12'(-560), 12'(2000), 12'(-90), 12'(-20)};
    initLevel = 12'(1000);
    doReset();
    for (int i = 0; i < 3; i++) sendBit(1, 0, 5'b00000, 0);
    sendBit(1, 0, 5'b00100, -2048);
    checkVal("R8 main tap high clamp", wOut(2), 2047);
    checkVal("R8 post tap low clamp", wOut(3), -2048);
    checkVal("R8 level low clamp", int'(level), -2048);

    // R10: fixed-position bits set, same result as above would give
    doReset();
    for (int i = 0; i < 3; i++) sendBit(1, 0, 5'b10011, 0);
    sendBit(1, 2, 5'b10111, 1400);
    checkVal("R10 level", int'(level), 1100);
    checkVal("R10 main tap", wOut(2), 1900);
    checkVal("R10 post tap", wOut(3), -460);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule